// File: doc/BRIEF.md
# Double-SHA-256 Nonce Search Engine

This block looks for a proof-of-work nonce over an 80-byte block header. The caller supplies the chaining state left by compressing the first 64 header bytes, along with the 12 fixed tail bytes that precede the nonce. For each candidate nonce the engine builds a 64-byte block from the tail words, the nonce and fixed padding. It compresses that block starting from the supplied chaining state. It then compresses the resulting 32-byte digest a second time, as its own padded block, starting from the standard initial hash value.

The second digest is judged in two steps. First it must have a programmable number of leading zero bytes. Only if that holds is it compared as a 256-bit number against a target. A single iterative compression unit carries out one round per clock and is shared by both passes. A state machine moves through the states IDLE, PASS1, PASS2, JUDGE, FOUND and EXHAUST:

- IDLE, FOUND or EXHAUST go to PASS1 when `start` is seen. This loads `first_nonce`.
- PASS1 goes to PASS2 when the compression unit reports completion.
- PASS2 goes to JUDGE on completion.
- JUDGE goes to FOUND on a hit.
- JUDGE goes to EXHAUST on a miss when the nonce is all ones.
- On any other miss, JUDGE returns to PASS1 with the nonce incremented.

Top module: `nonce_search`

## Requirements
- R1: After reset, `busy`, `found` and `exhausted` are all 0.
- R2: The first pass uses `mid_state` (word 0 in bits 255:224) as its starting state. Its block is built as follows:
  - words 0..2 are the three `tail` words (word 0 in bits 95:64), each byte-reversed;
  - word 3 is the byte-reversed nonce;
  - word 4 is 0x80000000;
  - words 5..14 are zero;
  - word 15 is 640.
  
  Each compression runs 64 rounds. Its output adds each working register to the matching starting word, modulo 2^32.
- R3: The second pass starts from the standard SHA-256 initial value. Its block is built as follows:
  - words 0..7 are the first digest;
  - word 8 is 0x80000000;
  - words 9..14 are zero;
  - word 15 is 256.
  
  The hash value is the eight output words concatenated, with word 0 most significant.
- R4: The search starts at `first_nonce` and tries nonces in ascending order. It reports the first nonce that is a hit.
- R5: A hash counts as a hit only when it is strictly less than `target`, read as an unsigned 256-bit number.
- R6: A hash also needs its `zero_bytes` most significant bytes to be zero (byte 0 is bits 255:248). A hash that fails this test is rejected even if it is below `target`.
- R7: If the nonce 0xFFFFFFFF is judged and is not a hit, `exhausted` goes to 1 and `nonce_out` reads 0xFFFFFFFF. If that last nonce is a hit, `found` is reported instead.
- R8: On a hit the engine stops with `found` = 1 and `nonce_out` holding the winning nonce. Both stay unchanged until the next `start`.
- R9: `busy` is 1 while a search runs. During that time `start` is ignored.
- R10: A `start` given in the FOUND or EXHAUST state clears the result and begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search when not busy |
| mid_state | input | 256 | Chaining state after the first 64 header bytes |
| tail | input | 96 | Fixed header tail words, header byte order |
| first_nonce | input | 32 | First nonce to try |
| target | input | 256 | Expanded difficulty target |
| zero_bytes | input | 6 | Required count of leading zero bytes (0..32) |
| busy | output | 1 | Search in progress |
| found | output | 1 | Solution held in `nonce_out` |
| exhausted | output | 1 | Sweep reached 0xFFFFFFFF with no solution |
| nonce_out | output | 32 | Current or winning nonce |

## Verification
The assertions assume that `mid_state`, `tail`, `target` and `zero_bytes` stay constant for as long as `busy` is 1, because the engine reads them live in every pass and in the judge cycle. The stimulus therefore changes these inputs only on the clock cycle that raises `start` from a done or idle state. Stimulus also drives one extra `start` pulse in the middle of a run, while those inputs stay unchanged, to show that the pulse is ignored. Windows that end at 0xFFFFFFFF keep the exhaustion and strict-compare cases short.

// File: rtl/nsearch_pkg.sv
package nsearch_pkg;
    localparam int WORD_W     = 32;
    localparam int ROUNDS     = 64;
    localparam int BLK_WORDS  = 16;
    localparam int ST_WORDS   = 8;
    localparam int CNT_W      = $clog2(ROUNDS);
    localparam int HASH_W     = WORD_W * ST_WORDS;
    localparam int BLK_W      = WORD_W * BLK_WORDS;
    localparam int ZB_W       = $clog2(HASH_W / 8) + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HASH_W-1:0] hash_t;
    typedef logic [BLK_W-1:0]  block_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PASS1, ST_PASS2, ST_JUDGE, ST_FOUND, ST_EXHAUST
    } srch_state_e;

    localparam hash_t SHA_IV = {
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t bswap(input word_t x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic word_t big_s0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_s0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_s1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t round_k(input logic [CNT_W-1:0] i);
        case (i)
            6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
            6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
            6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
            6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
            6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
            6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
            6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
            6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
            6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
            6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
            6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
            6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
            6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
            6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
            6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
            6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
            6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
            6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
            6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
            6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
            6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
            6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
            6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
            6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
            6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
            6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
            6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
            6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
            6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
            6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
            6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
            6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
        endcase
    endfunction
endpackage

// File: rtl/sha_iter_core.sv
module sha_iter_core
    import nsearch_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go,
    input  hash_t  init_st,
    input  block_t blk,
    output logic   done,
    output hash_t  digest
);
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

    word_t            win [BLK_WORDS];
    word_t            v   [ST_WORDS];
    word_t            cv  [ST_WORDS];
    logic [CNT_W-1:0] rnd;
    logic             run;
    word_t            t1, t2, w_new;

    always_comb begin
        t1    = v[7] + big_s1(v[4]) + ((v[4] & v[5]) ^ (~v[4] & v[6]))
              + round_k(rnd) + win[0];
        t2    = big_s0(v[0]) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
        w_new = sml_s1(win[14]) + win[9] + sml_s0(win[1]) + win[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            done <= 1'b0;
            rnd  <= '0;
        end else if (go) begin
            run  <= 1'b1;
            done <= 1'b0;
            rnd  <= '0;
        end else if (run) begin
            rnd  <= rnd + 1'b1;
            run  <= (rnd != LAST_RND);
            done <= (rnd == LAST_RND);
        end else begin
            done <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (go) begin
            for (int i = 0; i < BLK_WORDS; i++) win[i] <= blk[BLK_W-1-WORD_W*i -: WORD_W];
            for (int i = 0; i < ST_WORDS; i++) begin
                v[i]  <= init_st[HASH_W-1-WORD_W*i -: WORD_W];
                cv[i] <= init_st[HASH_W-1-WORD_W*i -: WORD_W];
            end
        end else if (run) begin
            for (int i = 0; i < BLK_WORDS - 1; i++) win[i] <= win[i+1];
            win[BLK_WORDS-1] <= w_new;
            v[0] <= t1 + t2;
            v[1] <= v[0];
            v[2] <= v[1];
            v[3] <= v[2];
            v[4] <= v[3] + t1;
            v[5] <= v[4];
            v[6] <= v[5];
            v[7] <= v[6];
        end
    end

    for (genvar g = 0; g < ST_WORDS; g++) begin : g_out
        assign digest[HASH_W-1-WORD_W*g -: WORD_W] = cv[g] + v[g];
    end

    // R2: completion is a single-cycle pulse, never raised mid-run
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_not_while_running: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !done);
endmodule

// File: rtl/hash_judge.sv
module hash_judge
    import nsearch_pkg::*;
(
    input  hash_t           hash,
    input  hash_t           target,
    input  logic [ZB_W-1:0] zero_bytes,
    output logic            hit
);
    localparam int NBYTES = HASH_W / 8;

    logic [NBYTES-1:0] byte_ok;

    for (genvar b = 0; b < NBYTES; b++) begin : g_zb
        assign byte_ok[b] = (zero_bytes <= ZB_W'(b)) || (hash[HASH_W-1-8*b -: 8] == 8'h00);
    end

    // early reject: the magnitude compare only counts when the prefix passes
    assign hit = (&byte_ok) && (hash < target);
endmodule

// File: rtl/nonce_search.sv
module nonce_search
    import nsearch_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [255:0] mid_state,
    input  logic [95:0]  tail,
    input  logic [31:0]  first_nonce,
    input  logic [255:0] target,
    input  logic [5:0]   zero_bytes,
    output logic         busy,
    output logic         found,
    output logic         exhausted,
    output logic [31:0]  nonce_out
);
    localparam word_t PAD_BIT  = 32'h8000_0000;
    localparam word_t LEN_HDR  = 32'd640;
    localparam word_t LEN_DIG  = 32'd256;

    srch_state_e state_q, state_d;
    word_t       nonce_q;
    logic        fire_q;
    logic        c_done, hit, last;
    hash_t       c_init, c_digest;
    block_t      c_blk;
    logic        can_start;

    assign can_start = (state_q == ST_IDLE) || (state_q == ST_FOUND) || (state_q == ST_EXHAUST);
    assign last      = (nonce_q == '1);

    always_comb begin
        if (state_q == ST_PASS2) begin
            c_init = SHA_IV;
            c_blk  = {c_digest, PAD_BIT, {6*WORD_W{1'b0}}, LEN_DIG};
        end else begin
            c_init = mid_state;
            c_blk  = {bswap(tail[95:64]), bswap(tail[63:32]), bswap(tail[31:0]),
                      bswap(nonce_q), PAD_BIT, {10*WORD_W{1'b0}}, LEN_HDR};
        end
    end

    sha_iter_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (fire_q),
        .init_st (c_init),
        .blk     (c_blk),
        .done    (c_done),
        .digest  (c_digest)
    );

    hash_judge u_judge (
        .hash       (c_digest),
        .target     (target),
        .zero_bytes (zero_bytes),
        .hit        (hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FOUND, ST_EXHAUST: if (start) state_d = ST_PASS1;
            ST_PASS1: if (c_done) state_d = ST_PASS2;
            ST_PASS2: if (c_done) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (hit)       state_d = ST_FOUND;
                else if (last) state_d = ST_EXHAUST;
                else           state_d = ST_PASS1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nonce_q <= '0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (can_start && start) begin
                nonce_q <= first_nonce;
                fire_q  <= 1'b1;
            end else if (state_q == ST_PASS1 && c_done) begin
                fire_q  <= 1'b1;
            end else if (state_q == ST_JUDGE && !hit && !last) begin
                nonce_q <= nonce_q + 1'b1;
                fire_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state_q == ST_PASS1) || (state_q == ST_PASS2) || (state_q == ST_JUDGE);
        found     = (state_q == ST_FOUND);
        exhausted = (state_q == ST_EXHAUST);
        nonce_out = nonce_q;
    end

    // R8: a held result does not move without a new start
    a_r8_found_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !start) |=> (found && $stable(nonce_out)));
    // R7: exhaustion is only ever reported at the top of the nonce space
    a_r7_exhaust_top: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted |-> (nonce_out == 32'hFFFF_FFFF));
    // R4: each new trial after a judge uses the next nonce
    a_r4_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PASS1) && ($past(state_q) == ST_JUDGE)) |-> (nonce_q == $past(nonce_q) + 1'b1));
    // R5: a reported solution lay strictly below the target when judged
    a_r5_found_below: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found) |-> $past(c_digest < target));
    // R9: start during a run leaves the nonce alone
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_JUDGE) |=> (nonce_q == $past(nonce_q)));
endmodule

// File: tb/sim_nonce_search.sv
module sim_nonce_search;
    import nsearch_pkg::round_k;
    import nsearch_pkg::SHA_IV;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] mid_state = '0;
    logic [95:0]  tail = '0;
    logic [31:0]  first_nonce = '0;
    logic [255:0] target = '0;
    logic [5:0]   zero_bytes = '0;
    logic         busy, found, exhausted;
    logic [31:0]  nonce_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nonce_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mid_state(mid_state),
        .tail(tail), .first_nonce(first_nonce), .target(target),
        .zero_bytes(zero_bytes), .busy(busy), .found(found),
        .exhausted(exhausted), .nonce_out(nonce_out)
    );

    function automatic logic [31:0] m_rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] m_bs(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    function automatic logic [255:0] m_comp(input logic [255:0] st, input logic [511:0] b);
        logic [31:0] w [64];
        logic [31:0] x [8];
        logic [31:0] s1, s0, t1, t2;
        logic [255:0] r;
        for (int t = 0; t < 16; t++) w[t] = b[511-32*t -: 32];
        for (int t = 16; t < 64; t++) begin
            s0 = m_rr(w[t-15], 7) ^ m_rr(w[t-15], 18) ^ (w[t-15] >> 3);
            s1 = m_rr(w[t-2], 17) ^ m_rr(w[t-2], 19) ^ (w[t-2] >> 10);
            w[t] = w[t-16] + s0 + w[t-7] + s1;
        end
        for (int i = 0; i < 8; i++) x[i] = st[255-32*i -: 32];
        for (int t = 0; t < 64; t++) begin
            t1 = x[7] + (m_rr(x[4], 6) ^ m_rr(x[4], 11) ^ m_rr(x[4], 25))
               + ((x[4] & x[5]) ^ (~x[4] & x[6])) + round_k(6'(t)) + w[t];
            t2 = (m_rr(x[0], 2) ^ m_rr(x[0], 13) ^ m_rr(x[0], 22))
               + ((x[0] & x[1]) ^ (x[0] & x[2]) ^ (x[1] & x[2]));
            for (int i = 7; i > 0; i--) x[i] = x[i-1];
            x[4] = x[4] + t1;
            x[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) r[255-32*i -: 32] = st[255-32*i -: 32] + x[i];
        return r;
    endfunction

    function automatic logic [255:0] m_dhash(input logic [31:0] n);
        logic [511:0] b1, b2;
        logic [255:0] d1;
        b1 = {m_bs(tail[95:64]), m_bs(tail[63:32]), m_bs(tail[31:0]), m_bs(n),
              32'h80000000, 320'd0, 32'd640};
        d1 = m_comp(mid_state, b1);
        b2 = {d1, 32'h80000000, 192'd0, 32'd256};
        return m_comp(SHA_IV, b2);
    endfunction

    function automatic bit m_hit(input logic [255:0] h);
        for (int i = 0; i < 32; i++)
            if (i < int'(zero_bytes) && h[255-8*i -: 8] != 8'h00) return 1'b0;
        return h < target;
    endfunction

    // expected outcome: returns 1 and the nonce on a hit within cap trials
    task automatic m_search(input logic [31:0] s, input int cap, output bit hit, output logic [31:0] n);
        hit = 1'b0;
        n = s;
        for (int i = 0; i < cap; i++) begin
            if (m_hit(m_dhash(n))) begin
                hit = 1'b1;
                return;
            end
            if (n == 32'hFFFF_FFFF) return;
            n = n + 1;
        end
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic kick(input logic [31:0] s);
        @(negedge clk);
        first_nonce = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int i;
        for (i = 0; i < 20000; i++) begin
            if (found || exhausted) break;
            @(negedge clk);
        end
        if (i == 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s timeout: got %h expected %h", req, 0, 1);
        end
    endtask

    task automatic t_reset;
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "found", 32'(found), 0);
        chk("R1", "exhausted", 32'(exhausted), 0);
    endtask

    task automatic t_basic;
        bit eh;
        logic [31:0] en;
        mid_state = 256'h0123456789abcdef_fedcba9876543210_0f1e2d3c4b5a6978_8796a5b4c3d2e1f0;
        tail = 96'h11223344_55667788_99aabbcc;
        target = 256'd1 << 255;
        zero_bytes = 6'd0;
        m_search(32'h0000_1000, 60, eh, en);
        kick(32'h0000_1000);
        chk("R9", "busy after start", 32'(busy), 1);
        chk("R9", "found during run", 32'(found), 0);
        wait_done("R4");
        chk("R4", "found", 32'(found), 32'(eh));
        chk("R2", "winning nonce", nonce_out, en);
        chk("R3", "exhausted", 32'(exhausted), 0);
        repeat (20) @(negedge clk);
        chk("R8", "found held", 32'(found), 1);
        chk("R8", "nonce held", nonce_out, en);
    endtask

    task automatic t_restart_ignore;
        bit eh;
        logic [31:0] en;
        tail = 96'hdeadbeef_cafef00d_a5a55a5a;
        target = 256'd3 << 254;
        m_search(32'h8000_0000, 60, eh, en);
        kick(32'h8000_0000);
        chk("R10", "found cleared", 32'(found), 0);
        repeat (40) @(negedge clk);
        kick(32'h0000_0007);
        wait_done("R9");
        chk("R9", "found despite extra start", 32'(found), 32'(eh));
        chk("R9", "nonce despite extra start", nonce_out, en);
    endtask

    task automatic t_strict;
        logic [255:0] mn, h;
        bit eh;
        logic [31:0] en;
        tail = 96'h0badc0de_13572468_fedc0123;
        zero_bytes = 6'd0;
        mn = '1;
        for (int k = 0; k < 6; k++) begin
            h = m_dhash(32'hFFFF_FFFA + 32'(k));
            if (h < mn) mn = h;
        end
        target = mn;
        m_search(32'hFFFF_FFFA, 6, eh, en);
        kick(32'hFFFF_FFFA);
        wait_done("R5");
        chk("R5", "equal is not below", 32'(found), 32'(eh));
        chk("R7", "exhausted", 32'(exhausted), 32'(!eh));
        chk("R7", "nonce at top", nonce_out, 32'hFFFF_FFFF);
    endtask

    task automatic t_zero_reject;
        bit eh;
        logic [31:0] en;
        target = '1;
        zero_bytes = 6'd2;
        m_search(32'hFFFF_FFFC, 4, eh, en);
        kick(32'hFFFF_FFFC);
        wait_done("R6");
        chk("R6", "prefix reject found", 32'(found), 32'(eh));
        chk("R6", "prefix reject nonce", nonce_out, en);
        zero_bytes = 6'd0;
        kick(32'hFFFF_FFFC);
        wait_done("R6");
        chk("R6", "no prefix found", 32'(found), 1);
        chk("R6", "no prefix nonce", nonce_out, 32'hFFFF_FFFC);
    endtask

    task automatic t_last_hit;
        target = '1;
        zero_bytes = 6'd0;
        kick(32'hFFFF_FFFF);
        wait_done("R7");
        chk("R7", "last nonce hit found", 32'(found), 1);
        chk("R7", "last nonce not exhausted", 32'(exhausted), 0);
        target = '0;
        kick(32'hFFFF_FFFF);
        wait_done("R7");
        chk("R7", "zero target exhausted", 32'(exhausted), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_restart_ignore();
        t_strict();
        t_zero_reject();
        t_last_hit();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %h expected %h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule